// File: doc/BRIEF.md
# PC Sequencer with Zero-Overhead Repeat and Instruction Breakpoint

This block holds the word-addressed program counter of a fetch unit and works out its next value each time an instruction word is issued. By default the counter steps by one. A taken branch loads the branch target instead. A hardware repeat loop is also supported. When repeat is enabled in the status word and the counter sits on the loop-end address, the counter jumps back to the loop-start address. The loop count goes down by one on each pass. On the last pass the loop falls through and turns repeat off.

After the next counter value is chosen, it is compared against a breakpoint address, but only when debug is enabled. On a match the candidate counter and the status word are copied into save registers. The status word is then cleared except for its supervisor bit, and the counter is sent to a fixed trap vector. A small write port loads the status word, the loop registers and the breakpoint address. The fetch byte address is the counter times four.

Top module: `pcseq_top`

## Requirements
- R1: On a clock edge with reset low, the counter becomes RESET_PC (0xFFC0), and the status word, loop registers, breakpoint address and save registers all become 0. Without `issue_valid`, the counter holds its value.
- R2: An issued word with no branch and no loop-end hit advances the counter by one at the next edge. `fetch_addr` always equals the counter shifted left by 2.
- R3: An issued word with `br_taken` loads `br_target`. This also applies when the counter is on the loop-end address: no loop-back happens and the loop count is left unchanged.
- R4: An issued word with status bit 1 (repeat) set, the counter equal to loop-end, no branch, and a count other than 1 loads loop-start and decrements the count.
- R5: The same situation with a count of 1 advances the counter by one, clears status bit 1 and clears the count.
- R6: With status bit 1 clear, reaching the loop-end address just advances the counter by one.
- R7: If status bit 12 (debug) is set and the chosen next counter equals the breakpoint address, the following happens at the next edge:
  - the counter becomes TRAP_VEC (0x3FF0);
  - `bkpt_pc` takes the chosen next counter;
  - `bkpt_status` takes the status word after any loop update;
  - the status word keeps only bit 15.
- R8: The breakpoint check is applied after both branch and loop-back redirection, so it overrides either.
- R9: Register writes take effect at the next edge. The `wr_sel` codes are: 0 status, 1 loop-start, 2 loop-end, 3 loop count, 4 breakpoint address. Codes 5 to 7 change nothing.
- R10: If the sequencer itself updates the status word (loop exit or trap) or the count in the same cycle as a write to that register, the sequencer's value is kept and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | An instruction word is issued this cycle |
| br_taken | input | 1 | The issued word redirected the counter |
| br_target | input | PC_W | Branch target word address |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (see R9) |
| wr_data | input | 16 | Register write data |
| pc | output | PC_W | Current word-addressed counter |
| fetch_addr | output | PC_W+2 | Fetch byte address |
| bkpt_pc | output | PC_W | Counter saved on a breakpoint trap |
| bkpt_status | output | 16 | Status word saved on a breakpoint trap |
| status | output | 16 | Current status word |

## Verification
Every registered result appears one rising edge after the cycle that causes it: the counter, the status word, the save registers and the register writes. `fetch_addr` follows the counter with no added delay. The bench drives each stimulus on the falling edge. It then samples all outputs one nanosecond after the next rising edge, so each comparison sees exactly one edge's worth of change. The loop count has no port, so it is checked indirectly: the bench counts how many loop-backs occur before the loop falls through, and whether a branch at the loop end left the count untouched.

// File: rtl/pcseq_pkg.sv
// Package: shared constants and the register-select encoding for the PC sequencer.
// Assumes a 16-bit status word and write port.
package pcseq_pkg;
    localparam int ST_W    = 16;
    localparam int REP_BIT = 1;
    localparam int DBG_BIT = 12;
    localparam int SUP_BIT = 15;

    typedef enum logic [2:0] {
        SEL_STATUS = 3'd0,
        SEL_LSTART = 3'd1,
        SEL_LEND   = 3'd2,
        SEL_LCNT   = 3'd3,
        SEL_BKADDR = 3'd4
    } pcseq_sel_e;
endpackage

// File: rtl/pcseq_loop.sv
// pcseq_loop: picks the candidate next counter from branch, repeat-loop and
// sequential stepping, and the count update. Purely combinational.
// Assumes the caller qualifies all outputs with the issue strobe.
module pcseq_loop #(
    parameter int PC_W  = 16,
    parameter int CNT_W = 16
) (
    input  logic [PC_W-1:0]  cur_pc,
    input  logic             br_taken,
    input  logic [PC_W-1:0]  br_target,
    input  logic             rep_en,
    input  logic [PC_W-1:0]  loop_start,
    input  logic [PC_W-1:0]  loop_end,
    input  logic [CNT_W-1:0] loop_cnt,
    output logic [PC_W-1:0]  cand_pc,
    output logic             loop_back,
    output logic             loop_exit,
    output logic [CNT_W-1:0] cnt_next
);
    logic at_end;
    logic last_pass;

    assign at_end    = rep_en && !br_taken && (cur_pc == loop_end);
    assign last_pass = (loop_cnt == CNT_W'(1));

    // Choose branch, loop-back, or step; derive the count update.
    always_comb begin
        loop_back = 1'b0;
        loop_exit = 1'b0;
        cnt_next  = loop_cnt;
        if (br_taken) begin
            cand_pc = br_target;
        end else if (at_end && !last_pass) begin
            cand_pc   = loop_start;
            loop_back = 1'b1;
            cnt_next  = loop_cnt - CNT_W'(1);
        end else if (at_end) begin
            cand_pc   = cur_pc + PC_W'(1);
            loop_exit = 1'b1;
            cnt_next  = '0;
        end else begin
            cand_pc = cur_pc + PC_W'(1);
        end
    end
endmodule

// File: rtl/pcseq_trap.sv
// pcseq_trap: compares the candidate counter with the breakpoint address and,
// on a hit, redirects to the trap vector and masks the status word.
// Assumes status_mid already carries any loop-exit update.
module pcseq_trap
    import pcseq_pkg::*;
#(
    parameter int              PC_W     = 16,
    parameter logic [PC_W-1:0] TRAP_VEC = 16'h3FF0
) (
    input  logic [PC_W-1:0] cand_pc,
    input  logic [ST_W-1:0] status_mid,
    input  logic [PC_W-1:0] bk_addr,
    output logic            trap_hit,
    output logic [PC_W-1:0] pc_final,
    output logic [ST_W-1:0] status_final
);
    localparam logic [ST_W-1:0] SUP_MASK = ST_W'(1) << SUP_BIT;

    // Detect a breakpoint hit and form the redirected counter and status.
    always_comb begin
        trap_hit     = status_mid[DBG_BIT] && (cand_pc == bk_addr);
        pc_final     = trap_hit ? TRAP_VEC : cand_pc;
        status_final = trap_hit ? (status_mid & SUP_MASK) : status_mid;
    end
endmodule

// File: rtl/pcseq_top.sv
// pcseq_top: program counter sequencer with a hardware repeat loop and an
// instruction breakpoint. State advances only on issue_valid; register writes
// land one edge later and lose to the sequencer's own updates.
// Assumes PC_W and CNT_W are at most 16 (write data is 16 bits).
module pcseq_top
    import pcseq_pkg::*;
#(
    parameter int              PC_W     = 16,
    parameter int              CNT_W    = 16,
    parameter logic [PC_W-1:0] RESET_PC = 16'hFFC0,
    parameter logic [PC_W-1:0] TRAP_VEC = 16'h3FF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic              br_taken,
    input  logic [PC_W-1:0]   br_target,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [15:0]       wr_data,
    output logic [PC_W-1:0]   pc,
    output logic [PC_W+1:0]   fetch_addr,
    output logic [PC_W-1:0]   bkpt_pc,
    output logic [15:0]       bkpt_status,
    output logic [15:0]       status
);
    localparam logic [ST_W-1:0] REP_MASK = ST_W'(1) << REP_BIT;
    localparam logic [ST_W-1:0] SUP_MASK = ST_W'(1) << SUP_BIT;

    logic [PC_W-1:0]  pc_q, lstart_q, lend_q, bkaddr_q, bkpc_q;
    logic [CNT_W-1:0] lcnt_q;
    logic [ST_W-1:0]  status_q, bkst_q;

    logic [PC_W-1:0]  cand_pc, pc_new;
    logic [CNT_W-1:0] cnt_next;
    logic             loop_back, loop_exit, trap_hit;
    logic [ST_W-1:0]  status_mid, status_new;
    logic             seq_st_upd, seq_cnt_upd;

    pcseq_loop #(.PC_W(PC_W), .CNT_W(CNT_W)) u_loop (
        .cur_pc     (pc_q),
        .br_taken   (br_taken),
        .br_target  (br_target),
        .rep_en     (status_q[REP_BIT]),
        .loop_start (lstart_q),
        .loop_end   (lend_q),
        .loop_cnt   (lcnt_q),
        .cand_pc    (cand_pc),
        .loop_back  (loop_back),
        .loop_exit  (loop_exit),
        .cnt_next   (cnt_next)
    );

    // Status after the loop step: repeat flag drops on the final pass.
    assign status_mid = loop_exit ? (status_q & ~REP_MASK) : status_q;

    pcseq_trap #(.PC_W(PC_W), .TRAP_VEC(TRAP_VEC)) u_trap (
        .cand_pc      (cand_pc),
        .status_mid   (status_mid),
        .bk_addr      (bkaddr_q),
        .trap_hit     (trap_hit),
        .pc_final     (pc_new),
        .status_final (status_new)
    );

    assign seq_st_upd  = issue_valid && (loop_exit || trap_hit);
    assign seq_cnt_upd = issue_valid && (loop_back || loop_exit);

    // Sequencer state and register-port updates, sequencer first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q     <= RESET_PC;
            status_q <= '0;
            lstart_q <= '0;
            lend_q   <= '0;
            lcnt_q   <= '0;
            bkaddr_q <= '0;
            bkpc_q   <= '0;
            bkst_q   <= '0;
        end else begin
            if (issue_valid) pc_q <= pc_new;
            if (seq_st_upd)
                status_q <= status_new;
            else if (wr_en && wr_sel == SEL_STATUS)
                status_q <= wr_data;
            if (seq_cnt_upd)
                lcnt_q <= cnt_next;
            else if (wr_en && wr_sel == SEL_LCNT)
                lcnt_q <= wr_data[CNT_W-1:0];
            if (wr_en && wr_sel == SEL_LSTART) lstart_q <= wr_data[PC_W-1:0];
            if (wr_en && wr_sel == SEL_LEND)   lend_q   <= wr_data[PC_W-1:0];
            if (wr_en && wr_sel == SEL_BKADDR) bkaddr_q <= wr_data[PC_W-1:0];
            if (issue_valid && trap_hit) begin
                bkpc_q <= cand_pc;
                bkst_q <= status_mid;
            end
        end
    end

    assign pc          = pc_q;
    assign fetch_addr  = {pc_q, 2'b00};
    assign bkpt_pc     = bkpc_q;
    assign bkpt_status = bkst_q;
    assign status      = status_q;

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |=> $stable(pc_q)); // R1
    AST_BRANCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && br_taken && !trap_hit) |=> (pc_q == $past(br_target))); // R3
    AST_LOOP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && loop_back) |=> (lcnt_q == CNT_W'($past(lcnt_q) - CNT_W'(1)))); // R4
    AST_LOOP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && loop_exit) |=> (!status_q[REP_BIT] && lcnt_q == '0)); // R5
    AST_TRAP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && trap_hit) |=> (pc_q == TRAP_VEC && bkpc_q == $past(cand_pc)
                                       && (status_q & ~SUP_MASK) == '0)); // R7
endmodule

// File: tb/tb_pcseq_top.sv
module tb_pcseq_top;
    localparam int PC_W = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0, br_taken = 1'b0, wr_en = 1'b0;
    logic [15:0] br_target = '0, wr_data = '0;
    logic [2:0]  wr_sel = '0;
    logic [15:0] pc, bkpt_pc, bkpt_status, status;
    logic [17:0] fetch_addr;

    int checks = 0, failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pcseq_top dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .br_taken(br_taken),
        .br_target(br_target), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .pc(pc), .fetch_addr(fetch_addr), .bkpt_pc(bkpt_pc),
        .bkpt_status(bkpt_status), .status(status)
    );

    // issue, br, target, wr, sel, data, exp_pc, exp_status
    localparam int NV = 28;
    localparam logic [69:0] VEC [NV] = '{
        {1'b0,1'b0,16'h0000,1'b0,3'd0,16'h0000,16'hFFC0,16'h0000}, // R1 hold
        {1'b1,1'b0,16'h0000,1'b0,3'd0,16'h0000,16'hFFC1,16'h0000}, // R2 step
        {1'b1,1'b1,16'h0010,1'b0,3'd0,16'h0000,16'h0010,16'h0000}, // R3 branch
        {1'b0,1'b0,16'h0000,1'b1,3'd1,16'h0011,16'h0010,16'h0000}, // R9 start
        {1'b1,1'b0,16'h0000,1'b1,3'd2,16'h0012,16'h0011,16'h0000}, // R9 end
        {1'b0,1'b0,16'h0000,1'b1,3'd3,16'h0003,16'h0011,16'h0000}, // R9 count=3
        {1'b0,1'b0,16'h0000,1'b1,3'd0,16'h0002,16'h0011,16'h0002}, // R9 status
        {1'b1,1'b0,16'h0000,1'b0,3'd0,16'h0000,16'h0012,16'h0002}, // R2
        {1'b1,1'b0,16'h0000,1'b0,3'd0,16'h0000,16'h0011,16'h0002}, // R4 3->2
        {1'b1,1'b0,16'h0000,1'b0,3'd0,16'h0000,16'h0012,16'h0002},
        {1'b1,1'b0,16'h0000,1'b0,3'd0,16'h0000,16'h0011,16'h0002}, // R4 2->1
        {1'b1,1'b0,16'h0000,1'b0,3'd0,16'h0000,16'h0012,16'h0002},
        {1'b1,1'b0,16'h0000,1'b1,3'd0,16'h8006,16'h0013,16'h0000}, // R5 R10 exit
        {1'b1,1'b0,16'h0000,1'b0,3'd0,16'h0000,16'h0014,16'h0000}, // R2
        {1'b1,1'b1,16'h0012,1'b0,3'd0,16'h0000,16'h0012,16'h0000},
        {1'b1,1'b0,16'h0000,1'b0,3'd0,16'h0000,16'h0013,16'h0000}, // R6 no repeat
        {1'b0,1'b0,16'h0000,1'b1,3'd3,16'h0001,16'h0013,16'h0000}, // count=1
        {1'b0,1'b0,16'h0000,1'b1,3'd0,16'h0002,16'h0013,16'h0002},
        {1'b1,1'b1,16'h0012,1'b0,3'd0,16'h0000,16'h0012,16'h0002},
        {1'b1,1'b1,16'h0030,1'b0,3'd0,16'h0000,16'h0030,16'h0002}, // R3 at end
        {1'b1,1'b1,16'h0012,1'b0,3'd0,16'h0000,16'h0012,16'h0002},
        {1'b1,1'b0,16'h0000,1'b0,3'd0,16'h0000,16'h0013,16'h0000}, // R3 count kept=1
        {1'b0,1'b0,16'h0000,1'b1,3'd4,16'h0014,16'h0013,16'h0000}, // R9 bkpt
        {1'b0,1'b0,16'h0000,1'b1,3'd0,16'h9000,16'h0013,16'h9000},
        {1'b1,1'b0,16'h0000,1'b0,3'd0,16'h0000,16'h3FF0,16'h8000}, // R7 trap
        {1'b0,1'b0,16'h0000,1'b1,3'd0,16'h1002,16'h3FF0,16'h1002},
        {1'b0,1'b0,16'h0000,1'b1,3'd4,16'h0050,16'h3FF0,16'h1002},
        {1'b1,1'b1,16'h0050,1'b0,3'd0,16'h0000,16'h3FF0,16'h0000}  // R8 over branch
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // One cycle: drive on falling edge, sample 1 ns after the rising edge.
    task automatic step(input logic iv, input logic br, input logic [15:0] tgt,
                        input logic we, input logic [2:0] sel, input logic [15:0] d);
        @(negedge clk);
        issue_valid = iv; br_taken = br; br_target = tgt;
        wr_en = we; wr_sel = sel; wr_data = d;
        @(posedge clk);
        #1;
        issue_valid = 1'b0; br_taken = 1'b0; wr_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset pc", {16'h0, pc}, 32'h0000FFC0);
        chk("R1 reset fetch", {14'h0, fetch_addr}, 32'h0003FF00);
        chk("R1 reset status", {16'h0, status}, 32'h0);
        chk("R1 reset bkpt_pc", {16'h0, bkpt_pc}, 32'h0);
        chk("R1 reset bkpt_status", {16'h0, bkpt_status}, 32'h0);
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][69], VEC[i][68], VEC[i][67:52], VEC[i][51], VEC[i][50:48], VEC[i][47:32]);
            chk($sformatf("R2-R10 vec%0d pc", i), {16'h0, pc}, {16'h0, VEC[i][31:16]});
            chk($sformatf("R2 vec%0d fetch", i), {14'h0, fetch_addr}, {14'h0, VEC[i][31:16], 2'b00});
            chk($sformatf("R5 R7 R10 vec%0d status", i), {16'h0, status}, {16'h0, VEC[i][15:0]});
        end
        chk("R8 bkpt_pc after branch trap", {16'h0, bkpt_pc}, 32'h00000050);
        chk("R8 bkpt_status after branch trap", {16'h0, bkpt_status}, 32'h00001002);

        // R8: trap overrides loop-back
        step(1'b0, 1'b0, 16'h0, 1'b1, 3'd1, 16'h0040);
        step(1'b0, 1'b0, 16'h0, 1'b1, 3'd2, 16'h0041);
        step(1'b0, 1'b0, 16'h0, 1'b1, 3'd3, 16'h0002);
        step(1'b0, 1'b0, 16'h0, 1'b1, 3'd4, 16'h0040);
        step(1'b0, 1'b0, 16'h0, 1'b1, 3'd0, 16'h1002);
        step(1'b1, 1'b1, 16'h0041, 1'b0, 3'd0, 16'h0);
        chk("R8 reach loop end", {16'h0, pc}, 32'h00000041);
        step(1'b1, 1'b0, 16'h0, 1'b0, 3'd0, 16'h0);
        chk("R8 loop trap pc", {16'h0, pc}, 32'h00003FF0);
        chk("R8 loop trap bkpt_pc", {16'h0, bkpt_pc}, 32'h00000040);
        chk("R7 loop trap bkpt_status", {16'h0, bkpt_status}, 32'h00001002);
        chk("R7 loop trap status", {16'h0, status}, 32'h0);

        // R9: unused select codes change nothing
        step(1'b0, 1'b0, 16'h0, 1'b1, 3'd5, 16'hFFFF);
        step(1'b0, 1'b0, 16'h0, 1'b1, 3'd7, 16'hFFFF);
        chk("R9 ignored sel status", {16'h0, status}, 32'h0);
        chk("R9 ignored sel pc", {16'h0, pc}, 32'h00003FF0);
        step(1'b1, 1'b0, 16'h0, 1'b0, 3'd0, 16'h0);
        chk("R9 step after ignored", {16'h0, pc}, 32'h00003FF1);

        // R1: reset mid-run
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R1 mid reset pc", {16'h0, pc}, 32'h0000FFC0);
        chk("R1 mid reset bkpt_pc", {16'h0, bkpt_pc}, 32'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule